// File: doc/BRIEF.md
# Zero-Flag Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for a simple in-order processor datapath. It takes two operands and a 4-bit operation code and returns a result word together with a flag that is high when that result is all zeros. The execute stage uses the result for arithmetic, logic and address calculation. A branch unit uses the zero flag to resolve equal and not-equal branches after a subtraction.

Six operations are decoded: bitwise AND, OR and NOR, wrapping addition and subtraction, and a signed less-than compare that yields 0 or 1. Codes outside the supported set give a zero result. The block has no carry, overflow or trap output. The operand width is a parameter with a default of 32 bits.

Top module: `zf_alu`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of the two operands.
- R2: Operation code 4'b0001 gives the bitwise OR of the two operands.
- R3: Operation code 4'b0010 gives a_i + b_i modulo 2^32, with no flag raised on wrap.
- R4: Operation code 4'b0110 gives a_i - b_i modulo 2^32, with no flag raised on wrap.
- R5: Operation code 4'b0111 compares the operands as signed two's-complement values. The result is 1 in bit 0 when a_i < b_i, else 0, and bits 31..1 are always zero. The answer is correct even when a_i - b_i overflows.
- R6: Operation code 4'b1100 gives the bitwise NOR of the two operands.
- R7: Every other operation code gives a result of zero.
- R8: zero_o is 1 exactly when res_o equals zero, for every operation code, including the unused codes of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation code |
| res_o | output | 32 | Result word |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
The bench drives operands whose difference overflows, such as the most negative value against 1 and the most positive value against -1. A compare built on the sign of the difference alone would return the inverted answer there. It adds and subtracts across the 2^32 boundary to catch a result that saturates or clips, and it steps through all ten unused codes so that a decoder falling back to some real operation shows a non-zero result. It also forces results that are zero and results that differ from zero only in bit 31 or bit 0, so a zero flag that looks at only part of the word gives itself away.

// File: rtl/zf_alu_pkg.sv
package zf_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;
endpackage

// File: rtl/zf_alu_addsub.sv
module zf_alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] b_eff;

  // one adder for both: a + ~b + 1 when subtracting
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
endmodule

// File: rtl/zf_alu_logic.sv
module zf_alu_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] nor_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign and_o[g] = a_i[g] & b_i[g];
    assign or_o[g]  = a_i[g] | b_i[g];
    assign nor_o[g] = ~(a_i[g] | b_i[g]);
  end
endmodule

// File: rtl/zf_alu_slt.sv
module zf_alu_slt #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              a_sign_i,
  input  logic              b_sign_i,
  input  logic [DATA_W-1:0] diff_i,
  output logic [DATA_W-1:0] slt_o
);
  localparam int unsigned MSB = DATA_W - 1;
  logic lt;

  // differing signs: the negative operand is smaller, which avoids the overflowed difference
  assign lt    = (a_sign_i ^ b_sign_i) ? a_sign_i : diff_i[MSB];
  assign slt_o = {{(DATA_W-1){1'b0}}, lt};
endmodule

// File: rtl/zf_alu.sv
module zf_alu
  import zf_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, and_v, or_v, nor_v, slt_v;
  logic              use_sub;

  // the compare reuses the subtractor
  assign use_sub = (op_i == OP_SUB) || (op_i == OP_SLT);

  zf_alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (use_sub),
    .sum_o (sum)
  );

  zf_alu_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  zf_alu_slt #(.DATA_W(DATA_W)) i_slt (
    .a_sign_i (a_i[MSB]),
    .b_sign_i (b_i[MSB]),
    .diff_i   (sum),
    .slt_o    (slt_v)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = and_v;
      OP_OR:   res_o = or_v;
      OP_ADD,
      OP_SUB:  res_o = sum;
      OP_SLT:  res_o = slt_v;
      OP_NOR:  res_o = nor_v;
      default: res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;

  always_comb begin
    // R1
    and_no_extra_bits_chk: assert (op_i != OP_AND || (res_o & ~(a_i & b_i)) == '0);
    // R2
    or_covers_a_chk: assert (op_i != OP_OR || (res_o & a_i) == a_i);
    // R3
    add_inverse_zero_chk: assert (op_i != OP_ADD || a_i != (~b_i + 1'b1) || zero_o);
    // R4
    sub_equal_zero_chk: assert (op_i != OP_SUB || a_i != b_i || zero_o);
    // R5
    slt_upper_clear_chk: assert (op_i != OP_SLT || res_o[MSB:1] == '0);
    // R5
    slt_signed_chk: assert (op_i != OP_SLT || res_o[0] == ($signed(a_i) < $signed(b_i)));
    // R6
    nor_disjoint_chk: assert (op_i != OP_NOR || (res_o & (a_i | b_i)) == '0);
    // R7
    unused_code_zero_chk: assert (!(op_i inside {4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1001,
                                                 4'b1010, 4'b1011, 4'b1101, 4'b1110, 4'b1111})
                                  || zero_o);
  end
endmodule

// File: tb/test_zf_alu.sv
module test_zf_alu;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, res;
  logic [3:0]   op;
  logic         zero;
  int           checks = 0;
  int           errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  zf_alu #(.DATA_W(W)) i_zf_alu (
    .a_i    (a),
    .b_i    (b),
    .op_i   (op),
    .res_o  (res),
    .zero_o (zero)
  );

  function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1100: return ~(x | y);
      default: return '0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    logic [W-1:0] exp;
    @(posedge clk_i);
    #1;
    op = o; a = x; b = y;
    exp = model(o, x, y);
    @(negedge clk_i);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h res actual=%h expected=%h", req, o, x, y, res, exp);
    end
    checks++;
    if (zero !== (exp == '0)) begin
      errors++;
      $display("FAIL R8 (%s) op=%b a=%h b=%h zero actual=%b expected=%b", req, o, x, y, zero, exp == '0);
    end
  endtask

  task automatic t_logic_r1_r2_r6();
    apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1");
    apply(4'b0000, 32'hAAAA_AAAA, 32'h5555_5555, "R1");
    apply(4'b0001, 32'hF000_0000, 32'h0000_000F, "R2");
    apply(4'b0001, 32'h0, 32'h0, "R2");
    apply(4'b1100, 32'h1234_5678, 32'h0F0F_0000, "R6");
    apply(4'b1100, 32'hFFFF_FFFF, 32'h0, "R6");
    apply(4'b1100, 32'h0, 32'h0, "R6");
  endtask

  task automatic t_add_r3();
    apply(4'b0010, 32'd5, 32'd7, "R3");
    apply(4'b0010, 32'hFFFF_FFFF, 32'd1, "R3");
    apply(4'b0010, 32'h7FFF_FFFF, 32'd1, "R3");
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000, "R3");
  endtask

  task automatic t_sub_r4();
    apply(4'b0110, 32'd9, 32'd9, "R4");
    apply(4'b0110, 32'd0, 32'd1, "R4");
    apply(4'b0110, 32'h8000_0000, 32'd1, "R4");
    apply(4'b0110, 32'h8000_0001, 32'd1, "R4");
  endtask

  task automatic t_slt_r5();
    apply(4'b0111, 32'd3, 32'd4, "R5");
    apply(4'b0111, 32'd4, 32'd3, "R5");
    apply(4'b0111, 32'd4, 32'd4, "R5");
    apply(4'b0111, 32'hFFFF_FFFF, 32'd0, "R5");
    apply(4'b0111, 32'h8000_0000, 32'd1, "R5");
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5");
    apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
  endtask

  task automatic t_unused_r7();
    for (int c = 0; c < 16; c++) begin
      if (!(c inside {0, 1, 2, 6, 7, 12}))
        apply(c[3:0], 32'hDEAD_BEEF, 32'h1357_9BDF, "R7");
    end
  endtask

  task automatic t_random();
    logic [3:0] codes [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    for (int i = 0; i < 300; i++) begin
      apply(codes[i % 6], $urandom, $urandom, "R1..R6 random");
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (res !== 32'h0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R1/R8 idle res actual=%h expected=0 zero actual=%b expected=1", res, zero);
    end
    t_logic_r1_r2_r6();
    t_add_r3();
    t_sub_r4();
    t_slt_r5();
    t_unused_r7();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule